// File: doc/BRIEF.md
# Shared Byte-Port Bus Controller

This block lets a controller reach two banks of byte-wide ports over one shared bus: up to 16 ports on the local board and up to 16 ports on a removable plug. Both banks use the same 8-bit data lines and 4-bit address lines. The block uses a different control scheme for each bank. On-board ports are reached through one strobe line, and the port address tells the port whether the access is a read or a write. Plug ports are reached through separate read-enable and write-enable lines, and the strobe stays idle.

A request carries four things: a bank select, a direction, a port address and a write byte. The request is taken through a ready/valid handshake, and only while the block is idle. The block then runs a fixed sequence. First comes a setup clock, in which the address, and the data for a write, are driven. Next the control line is asserted for a set number of clocks. Last comes a recovery clock, in which the control line is released while the address and data are still held. For reads, the block stops driving the data lines for the whole access, and it samples the port's byte on the last asserted clock. The result comes back together with a one-clock done pulse. The active level of each of the three control lines is set by a parameter.

Top module: `pbus_ctrl`

## Requirements
- R1: While reset is applied and afterwards until a request is taken, req_ready is 1, rsp_done is 0, bus_d_oe is 0, and every control line is at its inactive level.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the clock after acceptance until the sequence ends. A req_valid held high during that time starts no extra access.
- R3: bus_addr carries the requested address (0 to 15) one full clock before the control line asserts, and for a write bus_d_out carries the write byte by that time.
- R4: The control line stays asserted for exactly HOLD_CYC consecutive clocks (default 2).
- R5: An on-board access (req_plug=0) asserts only bus_stb. bus_rd and bus_wr stay at their inactive levels throughout.
- R6: A plug access (req_plug=1) asserts bus_wr for a write and bus_rd for a read. bus_stb is never asserted during a plug access.
- R7: During the clock after the control line deasserts, bus_addr still carries the request address, and for a write bus_d_out still carries the write byte.
- R8: For a read, rsp_rdata returns the value on bus_d_in during the last asserted clock. rsp_done is high for exactly one clock, which is the clock after the control line deasserts.
- R9: bus_d_oe is 0 for the whole of a read, from acceptance through the clock after deassertion. For a write, bus_d_oe is 1 from the setup clock through the clock after deassertion.
- R10: Each control line rests at its inactive level. With the default parameters the levels are: bus_stb active high (rest 0), bus_rd active low (rest 1), bus_wr active low (rest 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_plug | input | 1 | 1 = plug port, 0 = on-board port |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Port address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| bus_d_out | output | 8 | Data lines, driven value |
| bus_d_oe | output | 1 | Data line output enable |
| bus_d_in | input | 8 | Data lines, sampled value |
| bus_addr | output | 4 | Port address lines |
| bus_stb | output | 1 | On-board strobe |
| bus_rd | output | 1 | Plug read enable |
| bus_wr | output | 1 | Plug write enable |

## Verification
All four request kinds are run: on-board read, on-board write, plug read and plug write. For each kind, the test checks which control line moves, so that a mix-up between strobe, read-enable and write-enable shows up as a wrong line. A sweep across all 16 addresses, with a different byte returned by each port, finds address or data bits that are stuck or swapped. Requests are sent back-to-back, and req_valid is held high while the block is busy. This shows whether the handshake holds off the next access, and whether setup, width and recovery stay correct from one access to the next.

// File: rtl/pbus_pkg.sv
// Shared types for the byte-port bus controller.
package pbus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_HOLD  = 2'd3
    } phase_t;
endpackage

// File: rtl/pbus_seq.sv
// Access sequencer: steps idle -> setup -> active (HOLD_CYC clocks) -> hold -> idle.
// Assumes start is raised only while the phase is idle.
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output phase_t phase,
    output logic   last_act
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign last_act = (phase == PH_ACT) && (cnt == CNT_LAST);

    // Phase register and width counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE:  if (start) phase <= PH_SETUP;
                PH_SETUP: begin
                    phase <= PH_ACT;
                    cnt   <= '0;
                end
                PH_ACT: begin
                    if (last_act) phase <= PH_HOLD;
                    else          cnt   <= cnt + 1'b1;
                end
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT) |-> (cnt < CNT_W'(HOLD_CYC)));
    // R4
    act_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACT && !last_act) |=> (phase == PH_ACT));
endmodule

// File: rtl/pbus_pol.sv
// Converts an internal active-high control into a pin of the selected active level.
module pbus_pol #(
    parameter bit ACT_HI = 1'b1
) (
    input  logic act,
    output logic pin
);
    generate
        if (ACT_HI) begin : g_hi
            assign pin = act;
        end else begin : g_lo
            assign pin = ~act;
        end
    endgenerate
endmodule

// File: rtl/pbus_drive.sv
// Bus side of the controller: holds the accepted request, decodes the control
// line from the bank and direction, and captures read data.
// Assumes phase comes from pbus_seq and load pulses only in idle.
module pbus_drive
    import pbus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_plug,
    input  logic              in_write,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  phase_t            phase,
    input  logic              last_act,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    output logic [ADDR_W-1:0] addr,
    output logic              stb_act,
    output logic              rd_act,
    output logic              wr_act,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic is_plug, is_write;

    // Latch the request fields at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_plug  <= 1'b0;
            is_write <= 1'b0;
            addr     <= '0;
            d_out    <= '0;
        end else if (load) begin
            is_plug  <= in_plug;
            is_write <= in_write;
            addr     <= in_addr;
            d_out    <= in_wdata;
        end
    end

    // Capture read data on the last clock the control line is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rdata <= '0;
        else if (last_act && !is_write) rdata <= d_in;
    end

    // Decode control lines and output enable from the phase.
    always_comb begin
        stb_act = (phase == PH_ACT) && !is_plug;
        rd_act  = (phase == PH_ACT) && is_plug && !is_write;
        wr_act  = (phase == PH_ACT) && is_plug && is_write;
        d_oe    = (phase != PH_IDLE) && is_write;
        done    = (phase == PH_HOLD);
    end

    // R9
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act || (stb_act && !is_write)) |-> !d_oe);
    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> ($stable(addr) && $stable(d_out)));
endmodule

// File: rtl/pbus_ctrl.sv
// Top of the shared byte-port bus controller. Takes one request at a time via
// ready/valid and runs a setup / strobe / recovery sequence on the bus.
// Assumes the far side decodes the port from the address lines.
module pbus_ctrl
    import pbus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int HOLD_CYC  = 2,
    parameter bit STB_ACT_HI = 1'b1,
    parameter bit RD_ACT_HI  = 1'b0,
    parameter bit WR_ACT_HI  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_plug,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_stb,
    output logic              bus_rd,
    output logic              bus_wr
);
    phase_t phase;
    logic   last_act, accept;
    logic   stb_act, rd_act, wr_act;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    pbus_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept),
        .phase(phase), .last_act(last_act)
    );

    pbus_drive #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .in_plug(req_plug), .in_write(req_write),
        .in_addr(req_addr), .in_wdata(req_wdata),
        .phase(phase), .last_act(last_act), .d_in(bus_d_in),
        .d_out(bus_d_out), .d_oe(bus_d_oe), .addr(bus_addr),
        .stb_act(stb_act), .rd_act(rd_act), .wr_act(wr_act),
        .rdata(rsp_rdata), .done(rsp_done)
    );

    pbus_pol #(.ACT_HI(STB_ACT_HI)) u_pol_stb (.act(stb_act), .pin(bus_stb));
    pbus_pol #(.ACT_HI(RD_ACT_HI))  u_pol_rd  (.act(rd_act),  .pin(bus_rd));
    pbus_pol #(.ACT_HI(WR_ACT_HI))  u_pol_wr  (.act(wr_act),  .pin(bus_wr));

    // R5 R6
    line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({stb_act, rd_act, wr_act}) <= 1);
    // R3
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!stb_act && !rd_act && !wr_act && !req_ready));
    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_act || rd_act || wr_act) |-> $stable(bus_addr));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

// File: tb/pbus_ctrl_test.sv
// Scoreboard bench: the driver queues every accepted request and the monitor
// checks the bus and the result against the head of the queue.
module pbus_ctrl_test;
    localparam int HOLD = 2;

    typedef struct packed {
        logic       plug;
        logic       write;
        logic [3:0] addr;
        logic [7:0] wdata;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_plug = 1'b0, req_write = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rsp_done, bus_d_oe, bus_stb, bus_rd, bus_wr;
    logic [7:0] rsp_rdata, bus_d_out, bus_d_in;
    logic [3:0] bus_addr;

    int checks = 0, fails = 0, sent = 0, finished = 0;
    item_t q[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] port_val(input logic [3:0] a);
        return {a, ~a} ^ 8'h36;
    endfunction

    assign bus_d_in = bus_d_oe ? 8'h00 : port_val(bus_addr);

    pbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_plug(req_plug), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
        .bus_addr(bus_addr), .bus_stb(bus_stb), .bus_rd(bus_rd), .bus_wr(bus_wr)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: holds valid until taken, then pushes the expected item.
    task automatic send(input logic p, input logic w, input logic [3:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_plug = p; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        q.push_back('{plug: p, write: w, addr: a, wdata: d});
        sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor
    logic       prev_ctrl = 1'b0, prev_done = 1'b0;
    logic [3:0] prev_addr = '0;
    int         width = 0;
    always @(negedge clk) begin
        logic ctrl;
        item_t it;
        ctrl = bus_stb || !bus_rd || !bus_wr;
        if (rst_n) begin
            if (ctrl) chk(!req_ready, "R2 ready low while busy", req_ready, 0);
            if (ctrl && !prev_ctrl) begin
                if (q.size() == 0) chk(1'b0, "R2 access without request", 1, 0);
                else begin
                    it = q[0];
                    if (it.plug) begin
                        chk(!bus_stb, "R6 strobe idle on plug", bus_stb, 0);
                        chk(bus_rd == it.write && bus_wr == !it.write, "R6 rd/wr line",
                            {bus_rd, bus_wr}, {it.write, !it.write});
                    end else
                        chk(bus_stb && bus_rd && bus_wr, "R5 strobe only",
                            {bus_stb, bus_rd, bus_wr}, 3'b111);
                    chk(prev_addr == it.addr && bus_addr == it.addr, "R3 address setup",
                        prev_addr, it.addr);
                    chk(bus_d_oe == it.write, "R9 output enable", bus_d_oe, it.write);
                    if (it.write) chk(bus_d_out == it.wdata, "R3 write data", bus_d_out, it.wdata);
                end
            end
            if (ctrl) width++;
            if (rsp_done) begin
                chk(!prev_done, "R8 done one clock", prev_done, 0);
                if (q.size() == 0) chk(1'b0, "R8 done without request", 1, 0);
                else begin
                    it = q.pop_front();
                    finished++;
                    chk(width == HOLD, "R4 control width", width, HOLD);
                    chk(!ctrl && bus_addr == it.addr, "R7 address held", bus_addr, it.addr);
                    chk(bus_d_oe == it.write, "R9 enable in recovery", bus_d_oe, it.write);
                    if (it.write) chk(bus_d_out == it.wdata, "R7 data held", bus_d_out, it.wdata);
                    else chk(rsp_rdata == port_val(it.addr), "R8 read data",
                             rsp_rdata, port_val(it.addr));
                end
                width = 0;
            end
        end
        prev_ctrl = ctrl; prev_done = rsp_done; prev_addr = bus_addr;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", finished, sent);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 R10
        chk(req_ready && !rsp_done && !bus_d_oe, "R1 reset state",
            {req_ready, rsp_done, bus_d_oe}, 3'b100);
        chk(!bus_stb && bus_rd && bus_wr, "R10 rest levels", {bus_stb, bus_rd, bus_wr}, 3'b011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_stb && bus_rd && bus_wr, "R1 idle after reset",
            {req_ready, bus_stb, bus_rd, bus_wr}, 4'b1011);
        send(1'b0, 1'b1, 4'h0, 8'hA5);
        send(1'b0, 1'b0, 4'hF, 8'h00);
        send(1'b1, 1'b1, 4'h5, 8'h3C);
        send(1'b1, 1'b0, 4'hA, 8'h00);
        // Back-to-back sweep, valid held high while busy (R2)
        for (int i = 0; i < 16; i++)
            send(i[0], i[1], 4'(i), 8'(i * 29 + 7));
        repeat (HOLD + 6) @(negedge clk);
        chk(q.size() == 0 && finished == sent, "R2 one access per request", finished, sent);
        chk(!bus_stb && bus_rd && bus_wr && !bus_d_oe, "R10 rest after traffic",
            {bus_stb, bus_rd, bus_wr, bus_d_oe}, 4'b0110);
        summary();
    end
endmodule